// File: doc/BRIEF.md
# Configuration Register Load Port

This block sits behind the pins of an asynchronous memory and turns certain bus write cycles into updates of two internal configuration words. When the configuration-enable pin is high, a write cycle does not reach the array. Instead, the value on the address bus is stored in either the bus-setup register or the refresh-setup register. Address bit 19 picks which one. The stored values leave the block as plain vectors for the rest of the device to decode.

All pins are assumed to be already synchronized to the internal clock. A write cycle ends when the address-valid, chip-enable or write-enable strobe rises. The block stores the address as it stood before that first rising strobe. It stores exactly once per cycle, however many strobes rise and in whatever order.

A second load path lets on-chip logic write either register. That path can never alter the power-down control bit of the refresh-setup register. Any load that arrives while the device is busy (not in standby) is dropped, and a sticky error flag records it.

Top module: `cr_load_port`

## Requirements
- R1: After reset, `bus_cfg` equals parameter BUS_RST (default 0x09D4F), `ref_cfg` equals REF_RST (default 0x00010), and `cfg_err` is 0.
- R2: A configuration write is a cycle with `cfg_en`=1 and `ce_n`=`we_n`=0. If the stored address has bit 19 set, `bus_cfg` takes that address on the clock edge at which the first rising strobe is sampled. `ref_cfg` is left unchanged.
- R3: A configuration write whose address has bit 19 clear loads `ref_cfg` in the same way and leaves `bus_cfg` unchanged.
- R4: The value stored is the address from the sample before the first rise of `adv_n`, `ce_n` or `we_n`. Later rises in the same cycle, and address changes after the first rise, do not reload either register.
- R5: `lb_n` and `ub_n` have no effect on a configuration write. `arr_byte_en` is 0 whenever `cfg_en` is 1.
- R6: With `cfg_en`=0, a write cycle leaves both registers unchanged and `arr_sel` is 1 while `ce_n` is low.
- R7: A read (`oe_n`=0, `we_n`=1, `ce_n`=0) with `cfg_en`=1 keeps `arr_oe` at 0 and changes no register. The same read with `cfg_en`=0 drives `arr_oe` to 1.
- R8: A load from either path at an edge where `dev_busy`=1 changes no register and sets `cfg_err`. `cfg_err` stays at 1 until reset.
- R9: A pulse on `sw_wr` loads `bus_cfg` (`sw_sel_bus`=1) or `ref_cfg` (`sw_sel_bus`=0) from `sw_data` at that edge. `ref_cfg` bit PD_BIT (default 4) keeps its old value on this path.
- R10: If a pin-path load and `sw_wr` fall on the same edge, only the pin-path value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration-enable pin, synchronized |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | ADDR_W | Address bus, also the register value |
| dev_busy | input | 1 | Device is not in standby |
| sw_wr | input | 1 | On-chip load request, one clock |
| sw_sel_bus | input | 1 | On-chip load target: 1 bus-setup, 0 refresh-setup |
| sw_data | input | ADDR_W | On-chip load value |
| bus_cfg | output | ADDR_W | Bus-setup register |
| ref_cfg | output | ADDR_W | Refresh-setup register |
| cfg_err | output | 1 | Sticky flag for a load dropped while busy |
| arr_sel | output | 1 | Access is for the array |
| arr_oe | output | 1 | Array read data may drive the bus |
| arr_byte_en | output | 2 | Array byte lanes {upper, lower} |

## Verification
Suppose the cycle tracker kept a stale "already stored" state, or dropped that state too early. A second release strobe would then reload a register with the changed address, or a whole cycle would be lost. Either fault shows on `bus_cfg` or `ref_cfg` one clock after the release edge.

A wrong target decode or a lost mask on the power-down bit shows at the next readback as a changed word in the wrong register. A lost error state shows on `cfg_err` one clock after the busy edge.

Randomly chosen release patterns and lane values, plus busy timing, are mixed with directed collisions between the two paths. This makes each of these faults appear within a few cycles of the stimulus that triggers it.

// File: rtl/cr_pkg.sv
package cr_pkg;
   typedef enum logic {
      TGT_REF = 1'b0,
      TGT_BUS = 1'b1
   } cr_tgt_e;

   function automatic logic rose(input logic prev, input logic cur);
      return ~prev & cur;
   endfunction
endpackage

// File: rtl/cr_capture.sv
module cr_capture #(
   parameter int W = 21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_en,
   input  logic         ce_n,
   input  logic         we_n,
   input  logic         adv_n,
   input  logic [W-1:0] addr,
   output logic         cap,
   output logic [W-1:0] cap_data
);
   import cr_pkg::*;

   logic         ce_q, we_q, adv_q;
   logic         live, live_q, done_q;
   logic [W-1:0] addr_q;
   logic         any_rise;

   // a configuration write is in flight while both strobes are low with enable high
   assign live     = cfg_en & ~ce_n & ~we_n;
   assign any_rise = rose(adv_q, adv_n) | rose(ce_q, ce_n) | rose(we_q, we_n);
   assign cap      = live_q & ~done_q & any_rise;
   assign cap_data = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b1;
         we_q   <= 1'b1;
         adv_q  <= 1'b1;
         live_q <= 1'b0;
         done_q <= 1'b0;
         addr_q <= '0;
      end else begin
         ce_q   <= ce_n;
         we_q   <= we_n;
         adv_q  <= adv_n;
         live_q <= live;
         addr_q <= addr;
         if (cap)
            done_q <= 1'b1;
         else if (!live)
            done_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cr_regfile.sv
module cr_regfile #(
   parameter int            W       = 21,
   parameter int            SEL_BIT = 19,
   parameter int            PD_BIT  = 4,
   parameter logic [W-1:0]  BUS_RST = 21'h09D4F,
   parameter logic [W-1:0]  REF_RST = 21'h00010,
   parameter bit            SW_EN   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         busy,
   input  logic         pin_cap,
   input  logic [W-1:0] pin_data,
   input  logic         sw_wr,
   input  logic         sw_sel_bus,
   input  logic [W-1:0] sw_data,
   output logic [W-1:0] bus_cfg,
   output logic [W-1:0] ref_cfg,
   output logic         err
);
   import cr_pkg::*;

   localparam logic [W-1:0] PD_MASK = W'(1) << PD_BIT;

   logic         sw_req, wr_req, accept;
   cr_tgt_e      tgt;
   logic [W-1:0] wdata;

   generate
      if (SW_EN) begin : g_sw
         assign sw_req = sw_wr;
      end else begin : g_nosw
         assign sw_req = 1'b0;
      end
   endgenerate

   // pin path has priority over the on-chip path
   assign wr_req = pin_cap | sw_req;
   assign tgt    = pin_cap ? cr_tgt_e'(pin_data[SEL_BIT]) : cr_tgt_e'(sw_sel_bus);
   assign wdata  = pin_cap ? pin_data : sw_data;
   assign accept = wr_req & ~busy;

   generate
      for (genvar r = 0; r < 2; r++) begin : g_reg
         localparam logic [W-1:0] RV   = (r == 1) ? BUS_RST : REF_RST;
         localparam logic [W-1:0] KEEP = (r == 1) ? '0 : PD_MASK;
         localparam cr_tgt_e      ME   = (r == 1) ? TGT_BUS : TGT_REF;
         logic [W-1:0] q;
         logic         hit;
         assign hit = accept & (tgt == ME);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RV;
            else if (hit)
               q <= pin_cap ? wdata : ((wdata & ~KEEP) | (q & KEEP));
         end
      end
   endgenerate

   assign bus_cfg = g_reg[1].q;
   assign ref_cfg = g_reg[0].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err <= 1'b0;
      else if (wr_req & busy)
         err <= 1'b1;
   end
endmodule

// File: rtl/cr_load_port.sv
module cr_load_port #(
   parameter int                 ADDR_W  = 21,
   parameter int                 SEL_BIT = 19,
   parameter int                 PD_BIT  = 4,
   parameter logic [ADDR_W-1:0]  BUS_RST = 21'h09D4F,
   parameter logic [ADDR_W-1:0]  REF_RST = 21'h00010,
   parameter bit                 SW_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              adv_n,
   input  logic              lb_n,
   input  logic              ub_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dev_busy,
   input  logic              sw_wr,
   input  logic              sw_sel_bus,
   input  logic [ADDR_W-1:0] sw_data,
   output logic [ADDR_W-1:0] bus_cfg,
   output logic [ADDR_W-1:0] ref_cfg,
   output logic              cfg_err,
   output logic              arr_sel,
   output logic              arr_oe,
   output logic [1:0]        arr_byte_en
);
   generate
      if (SEL_BIT >= ADDR_W) begin : g_bad_sel
         $error("SEL_BIT outside address bus");
      end
      if (PD_BIT >= ADDR_W) begin : g_bad_pd
         $error("PD_BIT outside register");
      end
   endgenerate

   logic              pin_cap;
   logic [ADDR_W-1:0] pin_data;

   cr_capture #(.W(ADDR_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_en   (cfg_en),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .adv_n    (adv_n),
      .addr     (addr),
      .cap      (pin_cap),
      .cap_data (pin_data)
   );

   cr_regfile #(
      .W(ADDR_W), .SEL_BIT(SEL_BIT), .PD_BIT(PD_BIT),
      .BUS_RST(BUS_RST), .REF_RST(REF_RST), .SW_EN(SW_EN)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (dev_busy),
      .pin_cap    (pin_cap),
      .pin_data   (pin_data),
      .sw_wr      (sw_wr),
      .sw_sel_bus (sw_sel_bus),
      .sw_data    (sw_data),
      .bus_cfg    (bus_cfg),
      .ref_cfg    (ref_cfg),
      .err        (cfg_err)
   );

   // array side qualifiers: configuration cycles never reach the array
   assign arr_sel     = ~cfg_en & ~ce_n;
   assign arr_oe      = arr_sel & ~oe_n & we_n;
   assign arr_byte_en = arr_sel ? ~{ub_n, lb_n} : 2'b00;
endmodule

// File: rtl/cr_load_port_chk.sv
module cr_load_port_chk #(
   parameter int W      = 21,
   parameter int PD_BIT = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_en,
   input logic         dev_busy,
   input logic         arr_oe,
   input logic [1:0]   arr_byte_en,
   input logic [W-1:0] bus_cfg,
   input logic [W-1:0] ref_cfg,
   input logic         cfg_err,
   input logic         cap_pulse
);
   a_r2_cap_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |-> $past(cfg_en));

   a_r4_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> !cap_pulse);

   a_r5_no_lanes_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> (arr_byte_en == 2'b00));

   a_r7_no_drive_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> !arr_oe);

   a_r8_busy_holds_regs: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dev_busy) |-> ($stable(bus_cfg) && $stable(ref_cfg)));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   a_r9_pd_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cfg[PD_BIT] != $past(ref_cfg[PD_BIT])) |-> $past(cap_pulse));
endmodule

bind cr_load_port cr_load_port_chk #(.W(ADDR_W), .PD_BIT(PD_BIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en      (cfg_en),
   .dev_busy    (dev_busy),
   .arr_oe      (arr_oe),
   .arr_byte_en (arr_byte_en),
   .bus_cfg     (bus_cfg),
   .ref_cfg     (ref_cfg),
   .cfg_err     (cfg_err),
   .cap_pulse   (pin_cap)
);

// File: tb/test_cr_load_port.sv
module test_cr_load_port;
   localparam int          W       = 21;
   localparam logic [W-1:0] BUS_RST = 21'h09D4F;
   localparam logic [W-1:0] REF_RST = 21'h00010;
   localparam logic [W-1:0] PD_MASK = 21'h00010;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_en = 0, ce_n = 1, we_n = 1, oe_n = 1, adv_n = 1, lb_n = 1, ub_n = 1;
   logic [W-1:0] addr = '0, sw_data = '0;
   logic dev_busy = 0, sw_wr = 0, sw_sel_bus = 0;
   logic [W-1:0] bus_cfg, ref_cfg;
   logic cfg_err, arr_sel, arr_oe;
   logic [1:0] arr_byte_en;

   int total = 0, bad = 0;
   logic [W-1:0] eb, er;
   logic ee;

   always #5 clk = ~clk;

   cr_load_port i_cr_load_port (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ce_n(ce_n), .we_n(we_n),
      .oe_n(oe_n), .adv_n(adv_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr),
      .dev_busy(dev_busy), .sw_wr(sw_wr), .sw_sel_bus(sw_sel_bus), .sw_data(sw_data),
      .bus_cfg(bus_cfg), .ref_cfg(ref_cfg), .cfg_err(cfg_err), .arr_sel(arr_sel),
      .arr_oe(arr_oe), .arr_byte_en(arr_byte_en)
   );

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [W-1:0] sw_ref_next(input logic [W-1:0] old, input logic [W-1:0] d);
      return (d & ~PD_MASK) | (old & PD_MASK);
   endfunction

   task automatic check_all(input string req);
      chk({req, " bus"}, bus_cfg, eb);
      chk({req, " ref"}, ref_cfg, er);
      chk({req, " err"}, W'(cfg_err), W'(ee));
   endtask

   // rel: bit0 adv_n, bit1 ce_n, bit2 we_n rise first; nonzero
   task automatic pin_write(input logic [W-1:0] a, input logic [2:0] rel, input logic b,
                            input logic [1:0] lanes, input logic en);
      @(negedge clk);
      cfg_en = en; ce_n = 0; we_n = 0; adv_n = 0; addr = a; dev_busy = b;
      {ub_n, lb_n} = lanes;
      @(negedge clk);
      if (en) chk("R5 lanes off", W'(arr_byte_en), '0);
      else    chk("R6 arr_sel", W'(arr_sel), W'(1));
      @(negedge clk);
      adv_n = rel[0]; ce_n = rel[1]; we_n = rel[2]; addr = ~a;
      @(negedge clk);
      adv_n = 1; ce_n = 1; we_n = 1;
      @(negedge clk);
      dev_busy = 0; cfg_en = 0;
      @(negedge clk);
      if (en) begin
         if (b) ee = 1'b1;
         else if (a[19]) eb = a;
         else er = a;
      end
   endtask

   task automatic sw_write(input logic sel, input logic [W-1:0] d, input logic b);
      @(negedge clk);
      sw_wr = 1; sw_sel_bus = sel; sw_data = d; dev_busy = b;
      @(negedge clk);
      sw_wr = 0; dev_busy = 0;
      if (b) ee = 1'b1;
      else if (sel) eb = d;
      else er = sw_ref_next(er, d);
   endtask

   initial begin
      #1_000_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [W-1:0] a, d;
      void'($urandom(32'd4242));
      eb = BUS_RST; er = REF_RST; ee = 1'b0;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1;
      @(negedge clk);
      check_all("R1 after release");

      // directed: each strobe alone, both targets
      pin_write(21'h1A5A5A, 3'b100, 0, 2'b00, 1); check_all("R2 we release");
      pin_write(21'h035A33, 3'b010, 0, 2'b11, 1); check_all("R3 ce release");
      pin_write(21'h0F0F0F, 3'b001, 0, 2'b01, 1); check_all("R4 adv first then others");
      pin_write(21'h1FFFFF, 3'b111, 0, 2'b10, 1); check_all("R4 all rise together");
      pin_write(21'h012345, 3'b100, 0, 2'b00, 0); check_all("R6 array write");
      pin_write(21'h1C0000, 3'b100, 1, 2'b00, 1); check_all("R8 busy pin write");

      // R7 read cycles
      @(negedge clk); cfg_en = 1; ce_n = 0; oe_n = 0; we_n = 1;
      @(negedge clk); chk("R7 cfg read oe", W'(arr_oe), '0);
      cfg_en = 0;
      @(negedge clk); chk("R7 array read oe", W'(arr_oe), W'(1));
      ce_n = 1; oe_n = 1;
      @(negedge clk); check_all("R7 regs after reads");

      // R9 on-chip path
      sw_write(0, ~er, 0);               check_all("R9 ref keeps pd bit");
      sw_write(1, 21'h0ABCDE, 0);        check_all("R9 bus load");
      sw_write(1, 21'h000111, 1);        check_all("R8 busy sw write");
      pin_write(21'h000000, 3'b100, 0, 2'b00, 1); check_all("R9 pin clears pd bit");

      // R10 collision: pin to bus, sw to ref on the same edge
      @(negedge clk);
      cfg_en = 1; ce_n = 0; we_n = 0; adv_n = 0; addr = 21'h0BEEF1;
      @(negedge clk);
      we_n = 1; sw_wr = 1; sw_sel_bus = 0; sw_data = 21'h155555;
      @(negedge clk);
      sw_wr = 0; ce_n = 1; adv_n = 1; cfg_en = 0;
      eb = 21'h0BEEF1;
      @(negedge clk); check_all("R10 pin wins");

      // random mix
      for (int i = 0; i < 60; i++) begin
         a = W'($urandom);
         pin_write(a, 3'($urandom_range(1, 7)), ($urandom % 5) == 0,
                   2'($urandom), ($urandom % 6) != 0);
         check_all("R2 R3 R4 R5 R8 random pin");
         if ((i % 7) == 3) begin
            d = W'($urandom);
            sw_write(1'($urandom), d, ($urandom % 4) == 0);
            check_all("R9 random sw");
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule